// File: doc/BRIEF.md
# Byte-Wide Register Bank with Atomic Multi-Byte Groups

This block is a register bank addressed one byte at a time through a plain host port made of an address bus, a write strobe, a read strobe and 8-bit write and read data. It holds three kinds of storage. The first is configuration bytes that the host may read and rewrite freely. The second is status bytes whose bits are set by events from the surrounding core and cleared by the host writing ones. The third is wide values that span several consecutive byte addresses.

A wide value never changes partway. The host writes its bytes from the lowest address up to the highest, and the value is committed on the write to the highest byte. Any other access in between throws the partial sequence away. When the host reads the lowest byte of a wide value, the block takes a snapshot of the whole value. Later reads of the upper bytes return that snapshot, so the bytes the host reassembles all belong to one value. Status reads come from a shadow copy, which stops moving while a read strobe is high.

With default parameters the address map is as follows:
- 0x00 to 0x03: configuration bytes.
- 0x10 and 0x11: status bytes.
- 0x20 to 0x22: wide group 0, least significant byte at the lowest address.
- 0x23 to 0x25: wide group 1, least significant byte at the lowest address.

Top module: `regbank_top`

## Requirements
- R1: During and after reset, configuration byte i holds (0x40 + i) with bit 7 forced to 0, the wide groups hold zero, and host_rdata is zero.
- R2: A write to a configuration address replaces that whole byte, with bit 7 excepted, and a later read of that address returns the new byte.
- R3: Bit 7 of every configuration byte is don't-care: writing a 1 to it has no effect, and it always reads back as 0.
- R4: A write to an address outside the map changes no register, and a read from such an address returns 0x00.
- R5: A wide group takes its new value only on the write to its highest byte, after its lower bytes were written in ascending address order with no access in between. Byte b of the group is bits [8b+7:8b] of the value.
- R6: Any read, or any write to a different address, that falls between the writes of a sequence discards the staged bytes, and the committed value stays unchanged.
- R7: Writes to the bytes of a group that do not start at the lowest byte, or that skip a byte, commit nothing.
- R8: A read of a group's lowest byte snapshots the whole committed value. Reads of its upper bytes then return the snapshot even if a new value was committed meanwhile. A read of the highest byte ends the snapshot, and later reads return committed data.
- R9: Any access to an address outside the frozen group ends the snapshot.
- R10: Status bits are sticky. A 1 on sts_evt bit 8k+j sets bit j of status byte k, which stays set until cleared.
- R11: Writing to a status byte clears exactly the bits written as 1. Bits written as 0 keep their value.
- R12: When an event sets a status bit in the same cycle that the host writes 1 to clear it, the bit stays set.
- R13: A status read returns the flags as they stood before the read cycle. An event that arrives in the read cycle itself shows up only in a later read that comes after at least one cycle without a read.
- R14: host_rdata is registered. It updates on the clock edge that samples a read strobe (when the write strobe is low) and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Byte address of the access |
| host_wr | input | 1 | Write strobe; takes precedence over host_rd |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| sts_evt | input | NUM_STS*8 | Event pulses that set status bits |
| cfg_out | output | NUM_CFG*8 | Configuration bytes, byte i at [8i+7:8i] |
| grp_out | output | NUM_GRP*GRP_BYTES*8 | Committed wide values, group g at the g-th slice |

## Verification
Two pairs of functions can act on the same clock edge. In the first pair, a core event sets a status bit in the very cycle that the host writes a 1 to clear it. The bench drives both strobes on one edge and expects the bit to read back as set. In the second pair, a status event lands in the same cycle as a status read. The bench expects that read to return the old flags, and expects a later read, after an idle cycle has refreshed the shadow, to show the new bit.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the register bank.
// Assumes all index fields fit in 8 bits (small maps only).
package regbank_pkg;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_CFG,
        RGN_STS,
        RGN_GRP
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [7:0] idx;      // register or group number within the region
        logic [7:0] byte_sel; // byte within a wide group, 0 = lowest address
    } decode_t;

endpackage

// File: rtl/regbank_decode.sv
`timescale 1ns/1ps
// Module: regbank_decode
// Maps a host byte address to region, register/group index and byte lane.
// Assumes the regions do not overlap and that configuration starts at 0.
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_CFG   = 4,
    parameter int NUM_STS   = 2,
    parameter int STS_BASE  = 16,
    parameter int NUM_GRP   = 2,
    parameter int GRP_BYTES = 3,
    parameter int GRP_BASE  = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam logic [ADDR_W-1:0] CFG_END_A  = ADDR_W'(NUM_CFG);
    localparam logic [ADDR_W-1:0] STS_BASE_A = ADDR_W'(STS_BASE);
    localparam logic [ADDR_W-1:0] STS_END_A  = ADDR_W'(STS_BASE + NUM_STS);
    localparam logic [ADDR_W-1:0] GRP_BASE_A = ADDR_W'(GRP_BASE);
    localparam logic [ADDR_W-1:0] GRP_END_A  = ADDR_W'(GRP_BASE + NUM_GRP * GRP_BYTES);
    localparam logic [ADDR_W-1:0] GB_A       = ADDR_W'(GRP_BYTES);

    logic [ADDR_W-1:0] grp_off;

    // Offset of the address inside the wide-group window.
    always_comb grp_off = addr - GRP_BASE_A;

    // Region and index decode.
    always_comb begin
        dec = '{region: RGN_NONE, idx: 8'h00, byte_sel: 8'h00};
        if (addr < CFG_END_A) begin
            dec.region = RGN_CFG;
            dec.idx    = 8'(addr);
        end else if (addr >= STS_BASE_A && addr < STS_END_A) begin
            dec.region = RGN_STS;
            dec.idx    = 8'(addr - STS_BASE_A);
        end else if (addr >= GRP_BASE_A && addr < GRP_END_A) begin
            dec.region   = RGN_GRP;
            dec.idx      = 8'(grp_off / GB_A);
            dec.byte_sel = 8'(grp_off % GB_A);
        end
    end

endmodule

// File: rtl/regbank_cfg.sv
`timescale 1ns/1ps
// Module: regbank_cfg
// Configuration byte storage with per-register defaults and a write mask
// that keeps don't-care bits at zero. Assumes one write per cycle.
module regbank_cfg #(
    parameter int         NUM_CFG  = 4,
    parameter logic [7:0] WMASK    = 8'h7F,
    parameter logic [7:0] DEF_BASE = 8'h40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_idx,
    input  logic [7:0]           wdata,
    output logic [NUM_CFG*8-1:0] cfg_flat
);
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        localparam logic [7:0] DEF = (DEF_BASE + 8'(i)) & WMASK;
        logic [7:0] reg_q;

        // Load default on reset, full masked byte on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                reg_q <= DEF;
            else if (wr_en && wr_idx == 8'(i))
                reg_q <= wdata & WMASK;
        end

        assign cfg_flat[i*8 +: 8] = reg_q;
    end

endmodule

// File: rtl/regbank_sts.sv
`timescale 1ns/1ps
// Module: regbank_sts
// Sticky status flags set by core events and cleared by write-one.
// A shadow copy follows the flags except while a host read is strobed.
// Assumes an event wins over a clear that lands in the same cycle.
module regbank_sts #(
    parameter int NUM_STS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_STS*8-1:0] evt,
    input  logic                 clr_en,
    input  logic [7:0]           clr_idx,
    input  logic [7:0]           clr_data,
    input  logic                 rd_busy,
    output logic [NUM_STS*8-1:0] flags,
    output logic [NUM_STS*8-1:0] shadow
);
    for (genvar k = 0; k < NUM_STS; k++) begin : g_sts
        logic [7:0] flag_q;
        logic [7:0] shad_q;
        logic [7:0] clr_bits;

        // Bits the host asks to clear in this byte.
        always_comb clr_bits = (clr_en && clr_idx == 8'(k)) ? clr_data : 8'h00;

        // Sticky flags: clear first, then OR in events so set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 8'h00;
            else
                flag_q <= (flag_q & ~clr_bits) | evt[k*8 +: 8];
        end

        // Shadow follows flags whenever no read is in progress.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shad_q <= 8'h00;
            else if (!rd_busy)
                shad_q <= flag_q;
        end

        assign flags[k*8 +: 8]  = flag_q;
        assign shadow[k*8 +: 8] = shad_q;
    end

endmodule

// File: rtl/regbank_grp.sv
`timescale 1ns/1ps
// Module: regbank_grp
// Wide registers built from consecutive bytes. Writes are staged in
// ascending byte order and committed on the highest byte; any other access
// aborts the sequence. A read of byte 0 snapshots the whole value for the
// following byte reads until the top byte is read or the host leaves.
// Assumes acc_wr and acc_rd are never high together.
module regbank_grp #(
    parameter int NUM_GRP   = 2,
    parameter int GRP_BYTES = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           acc_wr,
    input  logic                           acc_rd,
    input  logic                           is_grp,
    input  logic [7:0]                     grp_idx,
    input  logic [7:0]                     byte_idx,
    input  logic [7:0]                     wdata,
    output logic [NUM_GRP*GRP_BYTES*8-1:0] grp_flat,
    output logic [7:0]                     rd_byte
);
    localparam int         GW   = GRP_BYTES * 8;
    localparam logic [7:0] LAST = 8'(GRP_BYTES - 1);
    localparam bit         MULTI = (GRP_BYTES > 1);

    logic [GRP_BYTES-1:0][7:0] commit_q [NUM_GRP];
    logic [GRP_BYTES-1:0][7:0] stage_q;
    logic [GRP_BYTES-1:0][7:0] commit_val;
    logic [GRP_BYTES-1:0][7:0] sel_commit;
    logic [GRP_BYTES-1:0][7:0] snap_q;
    logic                      seq_act_q;
    logic [7:0]                seq_grp_q;
    logic [7:0]                seq_next_q;
    logic                      frz_act_q;
    logic [7:0]                frz_grp_q;
    logic                      any_acc;
    logic                      seq_cont;
    logic                      commit_en;
    logic                      frz_hit;

    // Handy access qualifiers.
    always_comb begin
        any_acc   = acc_wr | acc_rd;
        seq_cont  = acc_wr && is_grp && seq_act_q && grp_idx == seq_grp_q
                    && byte_idx == seq_next_q;
        commit_en = acc_wr && is_grp && byte_idx == LAST && (!MULTI || seq_cont);
        frz_hit   = frz_act_q && frz_grp_q == grp_idx && byte_idx != 8'h00;
    end

    // Value to commit: staged lower bytes plus the incoming top byte.
    always_comb begin
        for (int b = 0; b < GRP_BYTES; b++)
            commit_val[b] = (8'(b) == LAST) ? wdata : stage_q[b];
    end

    // Committed value of the addressed group.
    always_comb begin
        sel_commit = '0;
        for (int g = 0; g < NUM_GRP; g++)
            if (grp_idx == 8'(g))
                sel_commit = commit_q[g];
    end

    // Write-sequence tracker: start on byte 0, advance in order, abort otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_act_q  <= 1'b0;
            seq_grp_q  <= 8'h00;
            seq_next_q <= 8'h00;
            stage_q    <= '0;
        end else if (any_acc) begin
            if (acc_wr && is_grp && byte_idx == 8'h00) begin
                stage_q[0] <= wdata;
                seq_act_q  <= MULTI;
                seq_grp_q  <= grp_idx;
                seq_next_q <= 8'h01;
            end else if (seq_cont) begin
                for (int b = 1; b < GRP_BYTES; b++)
                    if (byte_idx == 8'(b))
                        stage_q[b] <= wdata;
                seq_next_q <= seq_next_q + 8'h01;
                if (byte_idx == LAST)
                    seq_act_q <= 1'b0;
            end else begin
                seq_act_q <= 1'b0;
            end
        end
    end

    // Committed storage, one slot per group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_commit
        always_ff @(posedge clk) begin
            if (!rst_n)
                commit_q[g] <= '0;
            else if (commit_en && grp_idx == 8'(g))
                commit_q[g] <= commit_val;
        end
        assign grp_flat[g*GW +: GW] = commit_q[g];
    end

    // Read freeze: snapshot on byte 0, release on top byte or foreign access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_act_q <= 1'b0;
            frz_grp_q <= 8'h00;
            snap_q    <= '0;
        end else if (acc_rd && is_grp && byte_idx == 8'h00) begin
            frz_act_q <= MULTI;
            frz_grp_q <= grp_idx;
            snap_q    <= sel_commit;
        end else if (any_acc && !(is_grp && grp_idx == frz_grp_q)) begin
            frz_act_q <= 1'b0;
        end else if (acc_rd && is_grp && byte_idx == LAST) begin
            frz_act_q <= 1'b0;
        end
    end

    // Byte presented for a read: snapshot while frozen, committed otherwise.
    always_comb begin
        rd_byte = 8'h00;
        for (int b = 0; b < GRP_BYTES; b++)
            if (byte_idx == 8'(b))
                rd_byte = frz_hit ? snap_q[b] : sel_commit[b];
    end

endmodule

// File: rtl/regbank_top.sv
`timescale 1ns/1ps
// Module: regbank_top
// Byte-wide host register bank: configuration bytes, sticky status bytes
// read through a shadow, and wide values with atomic write and coherent
// read. A write strobe takes precedence over a read strobe in one cycle.
// Read data is registered and holds between reads.
module regbank_top
    import regbank_pkg::*;
#(
    parameter int         ADDR_W    = 6,
    parameter int         NUM_CFG   = 4,
    parameter logic [7:0] CFG_WMASK = 8'h7F,
    parameter logic [7:0] CFG_DEF   = 8'h40,
    parameter int         NUM_STS   = 2,
    parameter int         STS_BASE  = 16,
    parameter int         NUM_GRP   = 2,
    parameter int         GRP_BYTES = 3,
    parameter int         GRP_BASE  = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              host_addr,
    input  logic                           host_wr,
    input  logic                           host_rd,
    input  logic [7:0]                     host_wdata,
    output logic [7:0]                     host_rdata,
    input  logic [NUM_STS*8-1:0]           sts_evt,
    output logic [NUM_CFG*8-1:0]           cfg_out,
    output logic [NUM_GRP*GRP_BYTES*8-1:0] grp_out
);
    decode_t              dec;
    logic                 acc_wr;
    logic                 acc_rd;
    logic [NUM_STS*8-1:0] sts_flags;
    logic [NUM_STS*8-1:0] sts_shadow;
    logic [7:0]           grp_rd_byte;
    logic [7:0]           rd_mux;
    logic [7:0]           rdata_q;

    // Access qualification: write wins over read.
    always_comb begin
        acc_wr = host_wr;
        acc_rd = host_rd & ~host_wr;
    end

    regbank_decode #(
        .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .NUM_STS(NUM_STS),
        .STS_BASE(STS_BASE), .NUM_GRP(NUM_GRP), .GRP_BYTES(GRP_BYTES),
        .GRP_BASE(GRP_BASE)
    ) decode_i (
        .addr (host_addr),
        .dec  (dec)
    );

    regbank_cfg #(
        .NUM_CFG(NUM_CFG), .WMASK(CFG_WMASK), .DEF_BASE(CFG_DEF)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_wr && dec.region == RGN_CFG),
        .wr_idx   (dec.idx),
        .wdata    (host_wdata),
        .cfg_flat (cfg_out)
    );

    regbank_sts #(
        .NUM_STS(NUM_STS)
    ) sts_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (sts_evt),
        .clr_en   (acc_wr && dec.region == RGN_STS),
        .clr_idx  (dec.idx),
        .clr_data (host_wdata),
        .rd_busy  (host_rd),
        .flags    (sts_flags),
        .shadow   (sts_shadow)
    );

    regbank_grp #(
        .NUM_GRP(NUM_GRP), .GRP_BYTES(GRP_BYTES)
    ) grp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_wr   (acc_wr),
        .acc_rd   (acc_rd),
        .is_grp   (dec.region == RGN_GRP),
        .grp_idx  (dec.idx),
        .byte_idx (dec.byte_sel),
        .wdata    (host_wdata),
        .grp_flat (grp_out),
        .rd_byte  (grp_rd_byte)
    );

    // Read data selection by region; unmapped addresses read as zero.
    always_comb begin
        rd_mux = 8'h00;
        case (dec.region)
            RGN_CFG: begin
                for (int i = 0; i < NUM_CFG; i++)
                    if (dec.idx == 8'(i))
                        rd_mux = cfg_out[i*8 +: 8];
            end
            RGN_STS: begin
                for (int k = 0; k < NUM_STS; k++)
                    if (dec.idx == 8'(k))
                        rd_mux = sts_shadow[k*8 +: 8];
            end
            RGN_GRP: rd_mux = grp_rd_byte;
            default: rd_mux = 8'h00;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= 8'h00;
        else if (acc_rd)
            rdata_q <= rd_mux;
    end

    assign host_rdata = rdata_q;

endmodule

// File: rtl/regbank_chk.sv
`timescale 1ns/1ps
// Module: regbank_chk
// Protocol checks for regbank_top, attached with bind. Uses its own
// address decode so it stays independent of the design's decoder.
module regbank_chk #(
    parameter int ADDR_W    = 6,
    parameter int NUM_CFG   = 4,
    parameter int NUM_STS   = 2,
    parameter int STS_BASE  = 16,
    parameter int NUM_GRP   = 2,
    parameter int GRP_BYTES = 3,
    parameter int GRP_BASE  = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              host_addr,
    input logic                           host_wr,
    input logic                           host_rd,
    input logic [7:0]                     host_rdata,
    input logic [NUM_STS*8-1:0]           sts_evt,
    input logic [NUM_STS*8-1:0]           sts_flags,
    input logic [NUM_CFG*8-1:0]           cfg_out,
    input logic [NUM_GRP*GRP_BYTES*8-1:0] grp_out
);
    localparam int AI = int'(ADDR_W);

    int  a_int;
    logic in_cfg, in_sts, in_grp, top_byte, unmapped;

    // Independent decode of the current address.
    always_comb begin
        a_int    = int'(host_addr);
        in_cfg   = a_int < NUM_CFG;
        in_sts   = a_int >= STS_BASE && a_int < STS_BASE + NUM_STS;
        in_grp   = a_int >= GRP_BASE && a_int < GRP_BASE + NUM_GRP * GRP_BYTES;
        top_byte = in_grp && ((a_int - GRP_BASE) % GRP_BYTES) == GRP_BYTES - 1;
        unmapped = !(in_cfg || in_sts || in_grp) && AI > 0;
    end

    // R5: wide values move only after a write to a group's top byte.
    p_commit_on_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_out != $past(grp_out)) |-> $past(host_wr && top_byte));

    // R2: configuration bytes move only after a configuration write.
    p_cfg_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out != $past(cfg_out)) |-> $past(host_wr && in_cfg));

    // R4: an unmapped read returns zero.
    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && unmapped) |=> host_rdata == 8'h00);

    // R14: read data only moves after a read strobe.
    p_rdata_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata != $past(host_rdata)) |-> $past(host_rd && !host_wr));

    // R10: an event leaves its status bit set.
    p_evt_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_evt != '0) |=> ((sts_flags & $past(sts_evt)) == $past(sts_evt)));

endmodule

bind regbank_top regbank_chk #(
    .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .NUM_STS(NUM_STS),
    .STS_BASE(STS_BASE), .NUM_GRP(NUM_GRP), .GRP_BYTES(GRP_BYTES),
    .GRP_BASE(GRP_BASE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .sts_evt    (sts_evt),
    .sts_flags  (sts_flags),
    .cfg_out    (cfg_out),
    .grp_out    (grp_out)
);

// File: tb/regbank_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected bytes, a monitor compares
// them one negedge after the sampling edge. Direct port checks are inline.
module regbank_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [15:0] sts_evt = '0;
    logic [31:0] cfg_out;
    logic [47:0] grp_out;

    int checks = 0;
    int errors = 0;
    logic rd_q = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    regbank_top dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sts_evt(sts_evt), .cfg_out(cfg_out), .grp_out(grp_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Remember which edges sampled a read.
    always @(posedge clk) rd_q <= host_rd && !host_wr && rst_n;

    // Monitor: pop and compare read results.
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: unexpected read, actual %h expected none", host_rdata);
            end else begin
                chk(tag_q.pop_front(), 64'(host_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic pulse_evt(input logic [15:0] e);
        @(negedge clk); sts_evt = e;
        @(negedge clk); sts_evt = '0;
    endtask

    task automatic wr_evt(input logic [5:0] a, input logic [7:0] d, input logic [15:0] e);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1; sts_evt = e;
        @(negedge clk); host_wr = 1'b0; sts_evt = '0;
    endtask

    task automatic rd_evt(input logic [5:0] a, input logic [7:0] ex, input logic [15:0] e, input string tag);
        @(negedge clk); host_addr = a; host_rd = 1'b1; sts_evt = e;
        exp_q.push_back(ex); tag_q.push_back(tag);
        @(negedge clk); host_rd = 1'b0; sts_evt = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset cfg", 64'(cfg_out), 64'h43424140);
        chk("R1 reset grp", 64'(grp_out), 64'h0);
        chk("R1 reset rdata", 64'(host_rdata), 64'h0);
        rst_n = 1'b1;
        rd(6'h02, 8'h42, "R1 default read");

        // Configuration writes and don't-care bit.
        wr(6'h01, 8'hFF);
        chk("R3 bit7 masked", 64'(cfg_out[15:8]), 64'h7F);
        rd(6'h01, 8'h7F, "R2 readback");
        wr(6'h00, 8'h5A);
        rd(6'h00, 8'h5A, "R2 readback");

        // Unmapped address.
        wr(6'h3F, 8'h12);
        chk("R4 no change", 64'(cfg_out), 64'h43427F5A);
        rd(6'h3F, 8'h00, "R4 unmapped read");

        // Read data holds across a write.
        rd(6'h02, 8'h42, "R14 read");
        wr(6'h03, 8'h11);
        chk("R14 hold", 64'(host_rdata), 64'h42);

        // Atomic commit.
        wr(6'h20, 8'h11); wr(6'h21, 8'h22);
        chk("R5 not yet", 64'(grp_out), 64'h0);
        wr(6'h22, 8'h33);
        chk("R5 commit", 64'(grp_out[23:0]), 64'h332211);
        wr(6'h23, 8'h01); wr(6'h24, 8'h02); wr(6'h25, 8'h03);
        chk("R5 group1", 64'(grp_out), 64'h030201332211);

        // Interrupted sequences.
        wr(6'h20, 8'hAA); wr(6'h21, 8'hBB);
        rd(6'h05, 8'h00, "R6 interrupting read");
        wr(6'h22, 8'hCC);
        chk("R6 read abort", 64'(grp_out[23:0]), 64'h332211);
        wr(6'h20, 8'hAA); wr(6'h02, 8'h42); wr(6'h21, 8'hBB); wr(6'h22, 8'hCC);
        chk("R6 write abort", 64'(grp_out[23:0]), 64'h332211);

        // Order violations.
        wr(6'h21, 8'hDD); wr(6'h22, 8'hEE);
        chk("R7 no start", 64'(grp_out[23:0]), 64'h332211);
        wr(6'h25, 8'h09); wr(6'h24, 8'h09); wr(6'h23, 8'h09);
        chk("R7 descending", 64'(grp_out[47:24]), 64'h030201);
        wr(6'h20, 8'h01); wr(6'h22, 8'h02);
        chk("R7 skipped byte", 64'(grp_out[23:0]), 64'h332211);

        // Coherent read.
        rd(6'h20, 8'h11, "R8 low byte");
        wr(6'h20, 8'h44); wr(6'h21, 8'h55); wr(6'h22, 8'h66);
        chk("R8 commit under freeze", 64'(grp_out[23:0]), 64'h665544);
        rd(6'h21, 8'h22, "R8 frozen mid");
        rd(6'h22, 8'h33, "R8 frozen top");
        rd(6'h21, 8'h55, "R8 released");

        // Release by foreign access.
        rd(6'h20, 8'h44, "R9 low byte");
        rd(6'h00, 8'h5A, "R9 foreign read");
        wr(6'h20, 8'h77); wr(6'h21, 8'h88); wr(6'h22, 8'h99);
        rd(6'h21, 8'h88, "R9 released");

        // Status flags.
        rd(6'h10, 8'h00, "R10 clear start");
        pulse_evt(16'h0008);
        rd(6'h10, 8'h08, "R10 sticky");
        rd(6'h11, 8'h00, "R10 other byte");
        wr(6'h10, 8'hF7);
        rd(6'h10, 8'h08, "R11 zero keeps");
        wr(6'h10, 8'h08);
        rd(6'h10, 8'h00, "R11 one clears");

        // Event against clear in one cycle.
        wr_evt(6'h10, 8'h08, 16'h0008);
        rd(6'h10, 8'h08, "R12 set wins");
        wr(6'h10, 8'hFF);
        rd(6'h10, 8'h00, "R12 cleared after");

        // Event during a status read.
        rd_evt(6'h11, 8'h00, 16'h0100, "R13 old value");
        rd(6'h11, 8'h01, "R13 new value");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", 64'(exp_q.size()), 64'h0);
        finish_run();
    end

endmodule